// File: doc/BRIEF.md
# Single-Character 5x7 Dot-Matrix Display Core

This block holds one 7-bit character code and shows its 5x7 glyph by time-multiplexing seven row lines against five column lines. A host loads a code the way it would write a RAM location: it presents the code, pulls the active-low select low and pulses the active-low write strobe. The host side is asynchronous to the scan clock. The write strobe, the select and the data are each brought through synchronising flops. The code is committed once the rising edge of the strobe is seen on the scan side.

The stored code and the current row index go out to an external character-pattern source, which returns that row's five dot bits. The scan sequencer enables one row at a time. Every row gets the same slot length, and the rows follow a fixed order. A two-bit dimming input picks one of four modes: dark, lit for one seventh of each slot, lit for half of each slot, or lit for the whole slot. An active-low lamp-test input overrides every other input. It lights all five columns on each row at the one-seventh duty and leaves the stored code untouched.

Top module: `dot_char_core`

## Requirements
- R1: After reset, `rowOut` and `colOut` are all zero and `glyphCode` is 0.
- R2: A rising edge of `writeN` while `chipSelN` is low stores `charIn`, with bit 0 as the LSB. The stored code appears on `glyphCode` within 4 clocks after the edge.
- R3: A `writeN` pulse while `chipSelN` is high leaves the stored code unchanged. So does `chipSelN` going low with no `writeN` pulse.
- R4: The stored code stays unchanged across scan frames until the next valid write.
- R5: `rowOut` is one-hot or all zero. Bit r drives row r. The lit row index steps 0,1,...,6 and then wraps to 0, and each row owns a slot of `SLOT_CLKS` clocks.
- R6: `glyphRowSel` carries the row being scanned. While row r is lit, `colOut[i]` equals `glyphBits[i]` returned for that row. When no row is lit, `colOut` is zero.
- R7: With `dimCode` = 2'b11, each row is lit for `SLOT_CLKS` clocks per frame.
- R8: With `dimCode` = 2'b10, each row is lit for `SLOT_CLKS/2` clocks per frame.
- R9: With `dimCode` = 2'b01, each row is lit for `SLOT_CLKS/7` clocks per frame.
- R10: With `dimCode` = 2'b00 and lamp test inactive, every row and column output stays off.
- R11: While `testN` is low, all five columns are lit on every row for `SLOT_CLKS/7` clocks per frame. This holds whatever `dimCode`, `chipSelN` and `writeN` are doing. A `writeN` pulse with `chipSelN` high during lamp test does not change the code. After release, the stored glyph is shown again.
- R12: Changing `dimCode` never alters the stored code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chipSelN | input | 1 | Active-low select for host writes |
| writeN | input | 1 | Active-low write strobe; code stored on its rising edge |
| charIn | input | 7 | Character code from host, bit 0 LSB |
| dimCode | input | 2 | 00 dark, 01 one-seventh, 10 half, 11 full |
| testN | input | 1 | Active-low lamp test |
| glyphBits | input | 5 | Dot bits of the addressed glyph row from the pattern source |
| glyphCode | output | 7 | Stored code, addresses the pattern source |
| glyphRowSel | output | 3 | Row index addressing the pattern source |
| rowOut | output | 7 | One-hot row enables |
| colOut | output | 5 | Column enables |

## Verification
The bench builds the core with `SLOT_CLKS` = 14. That gives a frame of 98 clocks, a half window of 7 clocks and a one-seventh window of 2 clocks. A complete frame can therefore be tallied row by row, and exact lit-clock counts can be compared for every dimming mode and for lamp test within a few hundred cycles. A computed pattern table that differs per code and per row exposes any column or row misrouting.

// File: rtl/dot_char_pkg.sv
package dot_char_pkg;

  // Number of sub-slots one row slot is split into for the lowest duty.
  localparam int unsigned DIM_SUBSLOTS = 7;

  typedef enum logic [1:0] {
    DIM_DARK    = 2'b00,
    DIM_SEVENTH = 2'b01,
    DIM_HALF    = 2'b10,
    DIM_FULL    = 2'b11
  } dimMode_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic captureEn;   // commit synchronised code this cycle
    logic litEn;       // current clock lies inside the lit window
    logic lampOn;      // lamp test override active
    logic rowAdvance;  // last clock of the current row slot
  } ctlStrobes_t;

endpackage

// File: rtl/dot_char_ctrl.sv
module dot_char_ctrl
  import dot_char_pkg::*;
#(
  parameter int unsigned ROWS      = 7,
  parameter int unsigned SLOT_CLKS = 70,
  parameter int unsigned SYNC_LEN  = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     writeN,
  input  logic                     chipSelN,
  input  logic [1:0]               dimCode,
  input  logic                     testN,
  output ctlStrobes_t              strb,
  output logic [$clog2(ROWS)-1:0]  rowIdx
);

  localparam int unsigned ROW_W     = $clog2(ROWS);
  localparam int unsigned SLOT_W    = $clog2(SLOT_CLKS);
  localparam int unsigned EDGE_LEN  = SYNC_LEN + 1;
  localparam int unsigned HALF_CLKS = SLOT_CLKS / 2;
  localparam int unsigned SEV_CLKS  = SLOT_CLKS / DIM_SUBSLOTS;
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOT_CLKS - 1);
  localparam logic [ROW_W-1:0]  ROW_LAST  = ROW_W'(ROWS - 1);

  // Write strobe and select share one chain depth so their samples align.
  logic [EDGE_LEN-1:0] wrChain;
  logic [EDGE_LEN-1:0] csChain;
  logic [SYNC_LEN-1:0] testChain;
  logic [1:0]          dimChain [SYNC_LEN];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrChain   <= '1;
      csChain   <= '1;
      testChain <= '1;
    end else begin
      wrChain   <= {wrChain[EDGE_LEN-2:0], writeN};
      csChain   <= {csChain[EDGE_LEN-2:0], chipSelN};
      testChain <= {testChain[SYNC_LEN-2:0], testN};
    end
  end

  generate
    for (genvar s = 0; s < SYNC_LEN; s++) begin : g_dimSync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)       dimChain[s] <= DIM_DARK;
        else if (s == 0) dimChain[s] <= dimCode;
        else             dimChain[s] <= dimChain[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  // Rising edge of the strobe, with the select sampled while it was low.
  logic strobeRise;
  logic selWhileLow;
  assign strobeRise  = wrChain[EDGE_LEN-2] & ~wrChain[EDGE_LEN-1];
  assign selWhileLow = ~csChain[EDGE_LEN-1];

  // Scan sequencer.
  logic [SLOT_W-1:0] slotCnt;
  logic              slotEnd;
  assign slotEnd = (slotCnt == SLOT_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotCnt <= '0;
      rowIdx  <= '0;
    end else if (slotEnd) begin
      slotCnt <= '0;
      rowIdx  <= (rowIdx == ROW_LAST) ? '0 : rowIdx + 1'b1;
    end else begin
      slotCnt <= slotCnt + 1'b1;
    end
  end

  // Duty window.
  logic     inSeventh;
  logic     inHalf;
  logic     lampAct;
  dimMode_e dimMode;
  logic     litWin;

  assign inSeventh = (slotCnt < SLOT_W'(SEV_CLKS));
  assign inHalf    = (slotCnt < SLOT_W'(HALF_CLKS));
  assign lampAct   = ~testChain[SYNC_LEN-1];
  assign dimMode   = dimMode_e'(dimChain[SYNC_LEN-1]);

  always_comb begin
    unique case (dimMode)
      DIM_DARK:    litWin = 1'b0;
      DIM_SEVENTH: litWin = inSeventh;
      DIM_HALF:    litWin = inHalf;
      DIM_FULL:    litWin = 1'b1;
      default:     litWin = 1'b0;
    endcase
    if (lampAct) litWin = inSeventh;
  end

  always_comb begin
    strb.captureEn  = strobeRise & selWhileLow;
    strb.litEn      = litWin;
    strb.lampOn     = lampAct;
    strb.rowAdvance = slotEnd;
  end

  // R5: row order and slot length.
  a_r5_slot_bound: assert property (@(posedge clk) disable iff (!rstN)
    slotCnt <= SLOT_LAST);
  a_r5_row_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rowAdvance && rowIdx == ROW_LAST) |=> (rowIdx == '0));
  a_r5_row_step: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rowAdvance && rowIdx != ROW_LAST) |=> (rowIdx == $past(rowIdx) + 1'b1));
  a_r5_row_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rowAdvance |=> $stable(rowIdx));
  // R2: one commit per strobe edge.
  a_r2_single_capture: assert property (@(posedge clk) disable iff (!rstN)
    strb.captureEn |=> !strb.captureEn);

endmodule

// File: rtl/dot_char_dp.sv
module dot_char_dp
  import dot_char_pkg::*;
#(
  parameter int unsigned ROWS     = 7,
  parameter int unsigned COLS     = 5,
  parameter int unsigned CODE_W   = 7,
  parameter int unsigned SYNC_LEN = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctlStrobes_t              strb,
  input  logic [$clog2(ROWS)-1:0]  rowIdx,
  input  logic [CODE_W-1:0]        charIn,
  input  logic [COLS-1:0]          glyphBits,
  output logic [CODE_W-1:0]        glyphCode,
  output logic [ROWS-1:0]          rowOut,
  output logic [COLS-1:0]          colOut
);

  localparam int unsigned ROW_W = $clog2(ROWS);

  // Data synchroniser, same depth as the strobe edge sample.
  logic [CODE_W-1:0] dataChain [SYNC_LEN];

  generate
    for (genvar s = 0; s < SYNC_LEN; s++) begin : g_dataSync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)       dataChain[s] <= '0;
        else if (s == 0) dataChain[s] <= charIn;
        else             dataChain[s] <= dataChain[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  logic [CODE_W-1:0] storedCode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               storedCode <= '0;
    else if (strb.captureEn) storedCode <= dataChain[SYNC_LEN-1];
  end

  assign glyphCode = storedCode;

  // Row and column drive, registered.
  logic [ROWS-1:0] rowNext;
  logic [COLS-1:0] colNext;

  generate
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      assign rowNext[r] = strb.litEn & (rowIdx == ROW_W'(r));
    end
    for (genvar c = 0; c < COLS; c++) begin : g_col
      assign colNext[c] = strb.litEn & (strb.lampOn | glyphBits[c]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowOut <= '0;
      colOut <= '0;
    end else begin
      rowOut <= rowNext;
      colOut <= colNext;
    end
  end

  // R5: at most one row driven.
  a_r5_row_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rowOut));
  // R6: columns dark whenever no row is driven.
  a_r6_dark_cols: assert property (@(posedge clk) disable iff (!rstN)
    (rowOut == '0) |-> (colOut == '0));
  // R4: code held between commits.
  a_r4_code_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.captureEn |=> $stable(storedCode));
  // R11: lamp test lights every column.
  a_r11_lamp_cols: assert property (@(posedge clk) disable iff (!rstN)
    (strb.lampOn && strb.litEn) |=> (colOut == '1));

endmodule

// File: rtl/dot_char_core.sv
module dot_char_core
  import dot_char_pkg::*;
#(
  parameter int unsigned SLOT_CLKS = 70,
  parameter int unsigned SYNC_LEN  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       chipSelN,
  input  logic       writeN,
  input  logic [6:0] charIn,
  input  logic [1:0] dimCode,
  input  logic       testN,
  input  logic [4:0] glyphBits,
  output logic [6:0] glyphCode,
  output logic [2:0] glyphRowSel,
  output logic [6:0] rowOut,
  output logic [4:0] colOut
);

  localparam int unsigned ROWS   = 7;
  localparam int unsigned COLS   = 5;
  localparam int unsigned CODE_W = 7;

  ctlStrobes_t strb;
  logic [$clog2(ROWS)-1:0] rowIdx;

  dot_char_ctrl #(
    .ROWS(ROWS), .SLOT_CLKS(SLOT_CLKS), .SYNC_LEN(SYNC_LEN)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .writeN(writeN), .chipSelN(chipSelN),
    .dimCode(dimCode), .testN(testN), .strb(strb), .rowIdx(rowIdx)
  );

  dot_char_dp #(
    .ROWS(ROWS), .COLS(COLS), .CODE_W(CODE_W), .SYNC_LEN(SYNC_LEN)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rowIdx(rowIdx),
    .charIn(charIn), .glyphBits(glyphBits), .glyphCode(glyphCode),
    .rowOut(rowOut), .colOut(colOut)
  );

  assign glyphRowSel = rowIdx;

endmodule

// File: tb/tb_dot_char_core.sv
module tb_dot_char_core;

  localparam int SLOT  = 14;
  localparam int ROWS  = 7;
  localparam int FRAME = SLOT * ROWS;

  logic       clk = 1'b0;
  logic       rstN;
  logic       chipSelN, writeN, testN;
  logic [6:0] charIn;
  logic [1:0] dimCode;
  logic [4:0] glyphBits;
  logic [6:0] glyphCode;
  logic [2:0] glyphRowSel;
  logic [6:0] rowOut;
  logic [4:0] colOut;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dot_char_core #(.SLOT_CLKS(SLOT)) dut (
    .clk(clk), .rstN(rstN), .chipSelN(chipSelN), .writeN(writeN),
    .charIn(charIn), .dimCode(dimCode), .testN(testN),
    .glyphBits(glyphBits), .glyphCode(glyphCode),
    .glyphRowSel(glyphRowSel), .rowOut(rowOut), .colOut(colOut)
  );

  // Computed stand-in pattern table.
  function automatic logic [4:0] patRow(input logic [6:0] code, input logic [2:0] row);
    logic [7:0] v;
    v = 8'(code) * 8'd3 + 8'(row) * 8'd7 + 8'd1;
    return v[4:0] ^ {code[6:5], row};
  endfunction

  assign glyphBits = patRow(glyphCode, glyphRowSel);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [6:0] code, input logic sel);
    @(negedge clk); charIn = code; chipSelN = sel;
    @(negedge clk); writeN = 1'b0;
    repeat (3) @(negedge clk);
    writeN = 1'b1;
    repeat (4) @(negedge clk);
    chipSelN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // Tally one full frame; check columns and row order on the way.
  task automatic measureFrame(input string req, input int expPerRow,
                              input bit lamp, input logic [6:0] code);
    int cnt [ROWS];
    int prev = -1;
    bit colBad = 0, orderBad = 0, hotBad = 0;
    logic [4:0] badAct = '0, badExp = '0;
    for (int r = 0; r < ROWS; r++) cnt[r] = 0;
    for (int k = 0; k < FRAME; k++) begin
      @(negedge clk);
      if (rowOut == '0) begin
        if (colOut != '0) begin colBad = 1; badAct = colOut; badExp = '0; end
      end else if ($countones(rowOut) != 1) begin
        hotBad = 1;
      end else begin
        for (int r = 0; r < ROWS; r++) begin
          if (rowOut[r]) begin
            logic [4:0] e;
            cnt[r]++;
            e = lamp ? 5'h1f : patRow(code, 3'(r));
            if (colOut != e) begin colBad = 1; badAct = colOut; badExp = e; end
            if (prev >= 0 && r != prev && r != (prev + 1) % ROWS) orderBad = 1;
            prev = r;
          end
        end
      end
    end
    check({req, " R5 onehot"}, 32'(hotBad), 0);
    check({req, " R5 order"}, 32'(orderBad), 0);
    check({req, " R6 columns"}, {27'd0, badAct}, {27'd0, badExp});
    for (int r = 0; r < ROWS; r++)
      check($sformatf("%s lit clocks row %0d", req, r), 32'(cnt[r]), 32'(expPerRow));
  endtask

  task automatic settle();
    repeat (FRAME) @(negedge clk);
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R1 rowOut", 32'(rowOut), 0);
    check("R1 colOut", 32'(colOut), 0);
    check("R1 glyphCode", 32'(glyphCode), 0);
  endtask

  task automatic testWriteFull();
    hostWrite(7'h53, 1'b0);
    check("R2 code stored", 32'(glyphCode), 32'h53);
    dimCode = 2'b11; settle();
    measureFrame("R7 full", SLOT, 0, 7'h53);
  endtask

  task automatic testIgnoredWrites();
    hostWrite(7'h2a, 1'b1);
    check("R3 write with select high", 32'(glyphCode), 32'h53);
    @(negedge clk); charIn = 7'h11; chipSelN = 1'b0;
    repeat (8) @(negedge clk); chipSelN = 1'b1;
    repeat (4) @(negedge clk);
    check("R3 select without strobe", 32'(glyphCode), 32'h53);
  endtask

  task automatic testDimModes();
    hostWrite(7'h45, 1'b0);
    check("R2 second code", 32'(glyphCode), 32'h45);
    dimCode = 2'b10; settle();
    measureFrame("R8 half", SLOT / 2, 0, 7'h45);
    dimCode = 2'b01; settle();
    measureFrame("R9 seventh", SLOT / 7, 0, 7'h45);
    dimCode = 2'b00; settle();
    measureFrame("R10 blank", 0, 0, 7'h45);
    check("R12 code after dim changes", 32'(glyphCode), 32'h45);
  endtask

  task automatic testHold();
    dimCode = 2'b11;
    repeat (3) settle();
    check("R4 code held", 32'(glyphCode), 32'h45);
    measureFrame("R4 full", SLOT, 0, 7'h45);
  endtask

  task automatic testLamp();
    dimCode = 2'b00; testN = 1'b0; settle();
    measureFrame("R11 lamp over blank", SLOT / 7, 1, 7'h45);
    dimCode = 2'b11; settle();
    measureFrame("R11 lamp over full", SLOT / 7, 1, 7'h45);
    hostWrite(7'h7f, 1'b1);
    check("R11 code kept in lamp test", 32'(glyphCode), 32'h45);
    testN = 1'b1; settle();
    measureFrame("R11 released", SLOT, 0, 7'h45);
  endtask

  task automatic testCodeBits();
    hostWrite(7'h01, 1'b0);
    check("R2 LSB only", 32'(glyphCode), 32'h01);
    hostWrite(7'h40, 1'b0);
    check("R2 MSB only", 32'(glyphCode), 32'h40);
    settle();
    measureFrame("R6 code 40", SLOT, 0, 7'h40);
  endtask

  initial begin
    rstN = 1'b0; chipSelN = 1'b1; writeN = 1'b1; testN = 1'b1;
    charIn = '0; dimCode = 2'b11;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testWriteFull();
    testIgnoredWrites();
    testDimModes();
    testHold();
    testLamp();
    testCodeBits();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule